// File: doc/BRIEF.md
# PHY Calibration Init Sequencer

This block brings a serial-link PHY into a calibrated state after power-up. It does so with no software in the loop. It drives every access through a single-outstanding master port toward an indirect register bridge. After a start pulse it works through four phases:

1. It writes every populated entry of a 48-slot configuration table.
2. It forces a calibration cycle by clearing and then setting a control bit, with a timed pause between the two writes.
3. Optionally, it turns on a debug view and polls a status register until calibration reports done.
4. Optionally, it inspects the receiver offset code and retries calibration with a wider offset range whenever the code has saturated.

The table is a small register-file RAM, loaded through its own write port before start. The pause between steps comes from a cycle counter. Its length is set by a parameter, so that one millisecond at the system clock can be shrunk for simulation. The run ends with a single-cycle done pulse. An error flag and a warning flag then hold their result until the next start.

Top module: `phy_cal_seq`

## Requirements
- R1: With `skip_tbl_i` low, table slots are visited from 0 up to DEPTH-1. Each slot whose word is not all zero produces one write, with address = word[23:16] and data = word[15:0]. An all-zero slot produces no access. A slot with address 0 and a nonzero value is still written.
- R2: With `skip_tbl_i` high at start, no table entry is written and the run begins at the calibration toggle.
- R3: The toggle writes register 0x09 twice. The first write has bit 9 cleared and the second has bit 9 set. The second write is acknowledged at least DLY_CYCLES cycles after the first. The base value is the last value the table walk wrote to 0x09 in this run. If the walk wrote none, the base value is obtained by first reading 0x09.
- R4: With `poll_en_i` high, the toggle is followed by these accesses, in order:
  - a read of 0x0D;
  - a read of 0x10;
  - a write of 0x0D with bit 6 set;
  - a write of 0x10 with bits 9:3 replaced by 7'b1111000, giving (v & 0xFC07) | 0x03C0.
- R5: In poll mode, register 0x30 is read up to POLL_TRIES times, with a DLY_CYCLES pause between reads. Polling stops at the first read with bit 15 set. If no read has bit 15 set, `err_o` is raised.
- R6: After polling, whether it succeeded or not, 0x0D and then 0x10 are written back with the values read in R4.
- R7: With `ofs_chk_i` high, 0x1F and then 0x0B are read. The offset code is saturated when (0x1F & 0x1E) is 0x00 or 0x1E. If the code is saturated and the range field (0x0B & 0xC) is below 0xC, the field is raised by 4, 0x0B is written with the other bits kept, and the run repeats from the toggle, including R4 to R6 when enabled. If the code is saturated and the field is 0xC, no write follows and `warn_o` is raised. If the code is not saturated, the run ends.
- R8: At most one access is outstanding. Request, direction, address and write data are held stable from the cycle `acc_req_o` rises until the cycle `acc_ack_i` is seen. No request is made while idle.
- R9: `start_i` is ignored while `busy_o` is high. `done_o` is high for exactly one cycle at the end of a run. `err_o` and `warn_o` are cleared when a run starts and hold their value after it ends.
- R10: After reset the block is idle, with `busy_o`, `done_o`, `err_o`, `warn_o` and `acc_req_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; taken only while idle |
| skip_tbl_i | input | 1 | Skip the table walk (sampled at start) |
| poll_en_i | input | 1 | Enable debug-mode polling (sampled at start) |
| ofs_chk_i | input | 1 | Enable the offset-range retry (sampled at start) |
| tbl_we_i | input | 1 | Table slot write strobe |
| tbl_waddr_i | input | IW | Table slot index |
| tbl_wdata_i | input | 24 | Slot word: address in [23:16], value in [15:0] |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Calibration-done poll timed out |
| warn_o | output | 1 | Offset code saturated with the range at its maximum |
| acc_req_o | output | 1 | Bridge access request |
| acc_we_o | output | 1 | 1 = write, 0 = read |
| acc_addr_o | output | 8 | PHY register address |
| acc_wdata_o | output | 16 | Write data |
| acc_ack_i | input | 1 | Access complete (one cycle); read data valid |
| acc_rdata_i | input | 16 | Read data |

## Verification
The assertions assume the bridge completes each request with an acknowledge that lasts exactly one cycle. They also assume it never acknowledges when no request is pending, so the stability and idle-quiet properties can rely on the request being held until it is acknowledged. The bench bridge model meets this assumption: it waits a random zero to three cycles, then raises the acknowledge for a single cycle, and only while a request is present. The table is loaded only while the block is idle, so the entry under walk cannot change underneath an outstanding write.

// File: rtl/phy_cal_pkg.sv
`timescale 1ns/1ps
package phy_cal_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } tbl_ent_t;

  localparam logic [ADDR_W-1:0] REG_CAL   = 'h09;
  localparam logic [ADDR_W-1:0] REG_RANGE = 'h0B;
  localparam logic [ADDR_W-1:0] REG_DBGEN = 'h0D;
  localparam logic [ADDR_W-1:0] REG_DBGMD = 'h10;
  localparam logic [ADDR_W-1:0] REG_CODE  = 'h1F;
  localparam logic [ADDR_W-1:0] REG_STAT  = 'h30;

  localparam logic [DATA_W-1:0] CAL_BIT    = 'h0200;
  localparam logic [DATA_W-1:0] DBGEN_BIT  = 'h0040;
  localparam logic [DATA_W-1:0] DBGMD_MASK = 'h03F8;
  localparam logic [DATA_W-1:0] DBGMD_VAL  = 'h03C0;
  localparam logic [DATA_W-1:0] STAT_DONE  = 'h8000;
  localparam logic [DATA_W-1:0] CODE_MASK  = 'h001E;
  localparam logic [DATA_W-1:0] RANGE_MASK = 'h000C;
  localparam logic [DATA_W-1:0] RANGE_STEP = 'h0004;

  typedef enum logic [4:0] {
    S_IDLE, S_WALK, S_TOG, S_RD09, S_CLR09, S_WAIT, S_SET09,
    S_RD0D, S_RD10, S_WR0D, S_WR10, S_POLL, S_PWAIT,
    S_RS0D, S_RS10, S_RD1F, S_RD0B, S_WR0B, S_FIN
  } st_t;
endpackage

// File: rtl/phy_cal_table.sv
`timescale 1ns/1ps
module phy_cal_table import phy_cal_pkg::*; #(
  parameter int DEPTH = 48,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  tbl_ent_t      wdata_i,
  input  logic [IW-1:0] raddr_i,
  output tbl_ent_t      rdata_o
);
  tbl_ent_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && waddr_i == IW'(g)) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/phy_cal_timer.sv
`timescale 1ns/1ps
module phy_cal_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/phy_cal_offset.sv
`timescale 1ns/1ps
module phy_cal_offset import phy_cal_pkg::*; (
  input  logic [DATA_W-1:0] code_i,
  input  logic [DATA_W-1:0] range_i,
  output logic              sat_o,
  output logic              at_max_o,
  output logic [DATA_W-1:0] bumped_o
);
  logic [DATA_W-1:0] fld, inc;

  assign fld      = range_i & RANGE_MASK;
  assign inc      = range_i + RANGE_STEP;
  assign sat_o    = ((code_i & CODE_MASK) == '0) || ((code_i & CODE_MASK) == CODE_MASK);
  assign at_max_o = (fld == RANGE_MASK);
  assign bumped_o = (range_i & ~RANGE_MASK) | (inc & RANGE_MASK);
endmodule

// File: rtl/phy_cal_seq.sv
`timescale 1ns/1ps
module phy_cal_seq import phy_cal_pkg::*; #(
  parameter int DEPTH      = 48,
  parameter int DLY_CYCLES = 100000,
  parameter int POLL_TRIES = 11,
  localparam int IW        = $clog2(DEPTH),
  localparam int EW        = ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              skip_tbl_i,
  input  logic              poll_en_i,
  input  logic              ofs_chk_i,
  input  logic              tbl_we_i,
  input  logic [IW-1:0]     tbl_waddr_i,
  input  logic [EW-1:0]     tbl_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              warn_o,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic              acc_ack_i,
  input  logic [DATA_W-1:0] acc_rdata_i
);
  localparam int TW = $clog2(POLL_TRIES + 1);

  st_t               st;
  logic [IW-1:0]     idx;
  tbl_ent_t          ent;
  logic              ent_empty;
  logic              skip_q, poll_q, ofs_q, err_q, warn_q, cal_vld;
  logic [DATA_W-1:0] cal_val, sv_en, sv_md, code_q, wr_val;
  logic [TW-1:0]     tries;
  logic              tmr_run, tmr_exp;
  logic              sat, at_max;
  logic [DATA_W-1:0] bumped;
  st_t               post_cal;

  phy_cal_table #(.DEPTH(DEPTH), .IW(IW)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i), .waddr_i(tbl_waddr_i), .wdata_i(tbl_ent_t'(tbl_wdata_i)),
    .raddr_i(idx), .rdata_o(ent)
  );

  assign tmr_run = (st == S_WAIT) || (st == S_PWAIT);
  phy_cal_timer #(.CYCLES(DLY_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .run_i(tmr_run), .expire_o(tmr_exp)
  );

  phy_cal_offset u_ofs (
    .code_i(code_q), .range_i(acc_rdata_i),
    .sat_o(sat), .at_max_o(at_max), .bumped_o(bumped)
  );

  assign ent_empty = (ent.addr == '0) && (ent.data == '0);
  assign post_cal  = ofs_q ? S_RD1F : S_FIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= S_IDLE;
      idx     <= '0;
      skip_q  <= 1'b0;
      poll_q  <= 1'b0;
      ofs_q   <= 1'b0;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
      cal_vld <= 1'b0;
      cal_val <= '0;
      sv_en   <= '0;
      sv_md   <= '0;
      code_q  <= '0;
      wr_val  <= '0;
      tries   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          skip_q  <= skip_tbl_i;
          poll_q  <= poll_en_i;
          ofs_q   <= ofs_chk_i;
          err_q   <= 1'b0;
          warn_q  <= 1'b0;
          cal_vld <= 1'b0;
          idx     <= '0;
          st      <= skip_tbl_i ? S_TOG : S_WALK;
        end
        S_WALK: if (ent_empty || acc_ack_i) begin
          if (!ent_empty && ent.addr == REG_CAL) begin
            cal_val <= ent.data;
            cal_vld <= 1'b1;
          end
          if (idx == IW'(DEPTH - 1)) st <= S_TOG;
          else idx <= idx + 1'b1;
        end
        S_TOG:   st <= cal_vld ? S_CLR09 : S_RD09;
        S_RD09:  if (acc_ack_i) begin
          cal_val <= acc_rdata_i;
          cal_vld <= 1'b1;
          st      <= S_CLR09;
        end
        S_CLR09: if (acc_ack_i) st <= S_WAIT;
        S_WAIT:  if (tmr_exp) st <= S_SET09;
        S_SET09: if (acc_ack_i) st <= poll_q ? S_RD0D : post_cal;
        S_RD0D:  if (acc_ack_i) begin sv_en <= acc_rdata_i; st <= S_RD10; end
        S_RD10:  if (acc_ack_i) begin sv_md <= acc_rdata_i; st <= S_WR0D; end
        S_WR0D:  if (acc_ack_i) st <= S_WR10;
        S_WR10:  if (acc_ack_i) begin tries <= '0; st <= S_POLL; end
        S_POLL:  if (acc_ack_i) begin
          tries <= tries + 1'b1;
          if ((acc_rdata_i & STAT_DONE) != '0) st <= S_RS0D;
          else if (tries == TW'(POLL_TRIES - 1)) begin
            err_q <= 1'b1;
            st    <= S_RS0D;
          end else st <= S_PWAIT;
        end
        S_PWAIT: if (tmr_exp) st <= S_POLL;
        S_RS0D:  if (acc_ack_i) st <= S_RS10;
        S_RS10:  if (acc_ack_i) st <= post_cal;
        S_RD1F:  if (acc_ack_i) begin code_q <= acc_rdata_i; st <= S_RD0B; end
        S_RD0B:  if (acc_ack_i) begin
          if (sat && !at_max) begin
            wr_val <= bumped;
            st     <= S_WR0B;
          end else begin
            if (sat) warn_q <= 1'b1;
            st <= S_FIN;
          end
        end
        S_WR0B:  if (acc_ack_i) st <= S_CLR09;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    acc_req_o   = 1'b0;
    acc_we_o    = 1'b0;
    acc_addr_o  = '0;
    acc_wdata_o = '0;
    case (st)
      S_WALK: begin
        acc_req_o   = !ent_empty;
        acc_we_o    = 1'b1;
        acc_addr_o  = ent.addr;
        acc_wdata_o = ent.data;
      end
      S_RD09:  begin acc_req_o = 1'b1; acc_addr_o = REG_CAL; end
      S_CLR09: begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_CAL;
        acc_wdata_o = cal_val & ~CAL_BIT;
      end
      S_SET09: begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_CAL;
        acc_wdata_o = cal_val | CAL_BIT;
      end
      S_RD0D:  begin acc_req_o = 1'b1; acc_addr_o = REG_DBGEN; end
      S_RD10:  begin acc_req_o = 1'b1; acc_addr_o = REG_DBGMD; end
      S_WR0D:  begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_DBGEN;
        acc_wdata_o = sv_en | DBGEN_BIT;
      end
      S_WR10:  begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_DBGMD;
        acc_wdata_o = (sv_md & ~DBGMD_MASK) | DBGMD_VAL;
      end
      S_POLL:  begin acc_req_o = 1'b1; acc_addr_o = REG_STAT; end
      S_RS0D:  begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_DBGEN; acc_wdata_o = sv_en;
      end
      S_RS10:  begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_DBGMD; acc_wdata_o = sv_md;
      end
      S_RD1F:  begin acc_req_o = 1'b1; acc_addr_o = REG_CODE; end
      S_RD0B:  begin acc_req_o = 1'b1; acc_addr_o = REG_RANGE; end
      S_WR0B:  begin
        acc_req_o = 1'b1; acc_we_o = 1'b1; acc_addr_o = REG_RANGE; acc_wdata_o = wr_val;
      end
      default: ;
    endcase
  end

  assign busy_o = (st != S_IDLE);
  assign done_o = (st == S_FIN);
  assign err_o  = err_q;
  assign warn_o = warn_q;
endmodule

// File: rtl/phy_cal_seq_chk.sv
`timescale 1ns/1ps
module phy_cal_seq_chk import phy_cal_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              warn_o,
  input logic              acc_req_o,
  input logic              acc_we_o,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic [DATA_W-1:0] acc_wdata_o,
  input logic              acc_ack_i
);
  p_xfer_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o && !acc_ack_i |=> acc_req_o && $stable(acc_we_o) &&
                                $stable(acc_addr_o) && $stable(acc_wdata_o));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !acc_req_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_start_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_flags_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !err_o && !warn_o);

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(err_o) && $stable(warn_o));

  p_err_in_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> busy_o);

  p_warn_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_o) |-> done_o);
endmodule

bind phy_cal_seq phy_cal_seq_chk u_chk (.*);

// File: tb/phy_cal_seq_tb.sv
`timescale 1ns/1ps
module phy_cal_seq_tb;
  localparam int DEPTH = 48;
  localparam int DLY   = 16;
  localparam int TRIES = 4;
  localparam int IW    = $clog2(DEPTH);
  localparam int LOGN  = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, skip = 1'b0, poll = 1'b0, ofs = 1'b0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_wa = '0;
  logic [23:0] tbl_wd = '0;
  logic busy, done, err, warn, req, we, ack;
  logic [7:0] addr;
  logic [15:0] wdata, rdata;

  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  phy_cal_seq #(.DEPTH(DEPTH), .DLY_CYCLES(DLY), .POLL_TRIES(TRIES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .skip_tbl_i(skip),
    .poll_en_i(poll), .ofs_chk_i(ofs), .tbl_we_i(tbl_we), .tbl_waddr_i(tbl_wa),
    .tbl_wdata_i(tbl_wd), .busy_o(busy), .done_o(done), .err_o(err), .warn_o(warn),
    .acc_req_o(req), .acc_we_o(we), .acc_addr_o(addr), .acc_wdata_o(wdata),
    .acc_ack_i(ack), .acc_rdata_i(rdata)
  );

  logic [15:0] breg [256];
  logic [23:0] tbl [DEPTH];
  int pc, oc, ready_after, fix_after;
  logic [15:0] sat_code;
  bit lw [LOGN]; logic [7:0] la [LOGN]; logic [15:0] ld [LOGN]; int lc [LOGN]; int nlog;
  bit ew [LOGN]; logic [7:0] ea [LOGN]; logic [15:0] ed [LOGN]; int nexp;
  bit exp_err, exp_warn;
  int n_chk = 0, n_fail = 0, done_cnt = 0;

  function automatic logic [15:0] model_rd(input logic [7:0] a, input logic [15:0] rv,
                                           input int p, input int o);
    if (a == 8'h30) return (p >= ready_after) ? 16'h8000 : 16'h0000;
    if (a == 8'h1F) return (o < fix_after) ? sat_code : 16'h0010;
    return rv;
  endfunction

  // bridge model: random 0..3 cycle latency, one-cycle ack
  initial begin
    int lat;
    lat = 0; ack = 1'b0; rdata = '0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        lat = $urandom_range(0, 3);
      end else if (req && rst_n) begin
        if (lat > 0) lat--;
        else begin
          if (nlog < LOGN) begin
            lw[nlog] = we; la[nlog] = addr; ld[nlog] = we ? wdata : 16'h0; lc[nlog] = cyc;
            nlog++;
          end
          if (we) begin
            breg[addr] = wdata;
            if (addr == 8'h0B) oc++;
          end else begin
            if (addr == 8'h30) pc++;
            rdata = model_rd(addr, breg[addr], pc, oc);
          end
          ack = 1'b1;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic push(bit w, logic [7:0] a, logic [15:0] d);
    if (nexp < LOGN) begin ew[nexp] = w; ea[nexp] = a; ed[nexp] = w ? d : 16'h0; nexp++; end
  endtask

  task automatic gen_expected(bit sk, bit pl, bit of);
    logic [15:0] g [256];
    logic [15:0] cv, a0d, a10, code, r, nr;
    int gp, go;
    bit cok, again, sat;
    gp = 0; go = 0; cok = 0; cv = '0;
    for (int i = 0; i < 256; i++) g[i] = breg[i];
    nexp = 0; exp_err = 0; exp_warn = 0;
    if (!sk) for (int i = 0; i < DEPTH; i++) if (tbl[i] != 24'h0) begin   // R1
      push(1, tbl[i][23:16], tbl[i][15:0]);
      g[tbl[i][23:16]] = tbl[i][15:0];
      if (tbl[i][23:16] == 8'h0B) go++;
      if (tbl[i][23:16] == 8'h09) begin cv = tbl[i][15:0]; cok = 1; end
    end
    again = 1;
    while (again) begin
      again = 0;
      if (!cok) begin push(0, 8'h09, 0); cv = g[8'h09]; cok = 1; end
      push(1, 8'h09, cv & ~16'h0200);
      push(1, 8'h09, cv | 16'h0200);
      g[8'h09] = cv | 16'h0200;
      if (pl) begin                                                       // R4 R5 R6
        a0d = g[8'h0D]; a10 = g[8'h10];
        push(0, 8'h0D, 0); push(0, 8'h10, 0);
        push(1, 8'h0D, a0d | 16'h0040);
        push(1, 8'h10, (a10 & 16'hFC07) | 16'h03C0);
        for (int t = 1; t <= TRIES; t++) begin
          push(0, 8'h30, 0); gp++;
          if (gp >= ready_after) break;
          if (t == TRIES) exp_err = 1;
        end
        push(1, 8'h0D, a0d); push(1, 8'h10, a10);
        g[8'h0D] = a0d; g[8'h10] = a10;
      end
      if (of) begin                                                       // R7
        push(0, 8'h1F, 0);
        code = (go < fix_after) ? sat_code : 16'h0010;
        push(0, 8'h0B, 0);
        r = g[8'h0B];
        sat = ((code & 16'h1E) == 16'h0) || ((code & 16'h1E) == 16'h1E);
        if (sat) begin
          if ((r & 16'h000C) == 16'h000C) exp_warn = 1;
          else begin
            nr = (r & ~16'h000C) | ((r + 16'h4) & 16'h000C);
            push(1, 8'h0B, nr); g[8'h0B] = nr; go++; again = 1;
          end
        end
      end
    end
  endtask

  task automatic load_tbl();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); tbl_we = 1'b1; tbl_wa = IW'(i); tbl_wd = tbl[i];
    end
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic run(string rq, bit sk, bit pl, bit of, bit poke);
    int w;
    bit gap_seen;
    load_tbl();
    gen_expected(sk, pl, of);
    pc = 0; oc = 0; nlog = 0; done_cnt = 0;
    @(negedge clk); skip = sk; poll = pl; ofs = of; start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk); w++;
      start = (poke && w == 30);
    end
    start = 1'b0;
    chk(w < 20000, "R9", "watchdog expired", w, 0);
    chk(err == exp_err, "R5", "err_o at done", err, exp_err);
    chk(warn == exp_warn, "R7", "warn_o at done", warn, exp_warn);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(!busy, "R9", "busy after done", busy, 0);
    chk(err == exp_err && warn == exp_warn, "R9", "flags held", {err, warn}, {exp_err, exp_warn});
    chk(nlog == nexp, rq, "access count", nlog, nexp);
    for (int i = 0; i < nlog && i < nexp; i++)
      chk(lw[i] == ew[i] && la[i] == ea[i] && ld[i] == ed[i], rq,
          $sformatf("access %0d {we,addr,data}", i),
          {7'h0, lw[i], la[i], ld[i]}, {7'h0, ew[i], ea[i], ed[i]});
    gap_seen = 0;
    for (int i = 0; i + 1 < nlog; i++)
      if (!gap_seen && lw[i] && la[i] == 8'h09 && !ld[i][9] && lw[i+1] && la[i+1] == 8'h09 && ld[i+1][9]) begin
        gap_seen = 1;
        chk(lc[i+1] - lc[i] >= DLY, "R3", "toggle gap cycles", lc[i+1] - lc[i], DLY);
      end
  endtask

  task automatic clr_tbl();
    for (int i = 0; i < DEPTH; i++) tbl[i] = 24'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 global watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 256; i++) breg[i] = 16'(i * 16'h0101);
    clr_tbl();
    ready_after = 1; fix_after = 0; sat_code = 16'h0010; nlog = 0; pc = 0; oc = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !err && !warn && !req, "R10", "outputs in reset",
        {busy, done, err, warn, req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !req, "R10", "idle after reset", {busy, req}, 0);

    // R1 R3: walk with skips, address 0 entry, table value for 0x09
    tbl[0] = 24'h011234; tbl[3] = 24'h09525C; tbl[10] = 24'h000007; tbl[47] = 24'h2F0040;
    run("R1", 0, 0, 0, 0);

    // R2 R3: table skipped, 0x09 read first
    breg[8'h09] = 16'h924C;
    run("R2", 1, 0, 0, 0);

    // R4 R5 R6 R9: poll succeeds on third read, start poked mid-run
    breg[8'h0D] = 16'hEF2A; breg[8'h10] = 16'h000C; ready_after = 3;
    run("R4", 1, 1, 0, 1);

    // R5 R6: poll timeout raises err
    breg[8'h10] = 16'hFFFF; ready_after = 100;
    run("R5", 1, 1, 0, 0);

    // R7 R9: one bump then non-saturated code; err cleared from prior run
    breg[8'h0B] = 16'hB905; sat_code = 16'h0000; fix_after = 1;
    run("R7", 1, 0, 1, 0);

    // R7 R6: saturated all-ones code, range climbs to max, warn; poll each pass
    breg[8'h0B] = 16'hA904; sat_code = 16'h001E; fix_after = 99; ready_after = 1;
    run("R7", 1, 1, 1, 0);

    // R7: non-saturated code, no write to 0x0B
    sat_code = 16'h2807; fix_after = 99;
    run("R7", 0, 0, 1, 0);

    // random mix
    for (int k = 0; k < 6; k++) begin
      clr_tbl();
      for (int i = 0; i < DEPTH; i++) if ($urandom_range(0, 2) == 0) begin
        logic [7:0] a;
        a = 8'($urandom_range(0, 8'h2F));
        if (a == 8'h09 || a == 8'h0B || a == 8'h1F) a = 8'h05;
        tbl[i] = {a, 16'($urandom())};
      end
      for (int i = 0; i < 64; i++) breg[i] = 16'($urandom());
      ready_after = $urandom_range(1, 6);
      fix_after = $urandom_range(0, 3);
      case ($urandom_range(0, 2))
        0: sat_code = 16'h0000;
        1: sat_code = 16'h001E;
        default: sat_code = 16'($urandom());
      endcase
      run("R1", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule